// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block handles DRAM housekeeping next to an access controller. After reset it keeps the strobes idle for a start-up pause. It then issues a fixed number of dummy cycles. Each dummy cycle pulses only RAS and leaves CAS high. When the last dummy cycle has finished, it raises `init_done`. The access controller must not serve accesses before that flag is high.

From then on an interval timer marks a refresh as due at a fixed period. Each due refresh is added to a small saturating backlog count. While the backlog is non-zero, the sequencer requests the DRAM bus. Once it sees the grant, it runs CAS-before-RAS refresh cycles back to back until the backlog is empty, and then drops the request. The DRAM's own row counter selects the row, so no address is produced. WE and OE are left to the access controller.

A one-cycle `restart` pulse puts the sequencer back into the pause-and-initialize sequence. It is meant for use after the DRAM clocks have been stopped for longer than the retention period. Every duration is a parameter counted in clock cycles.

Top module: `dref_housekeeper`

## Requirements
- R1: While `rst` is high, and on the edge after a clock in which `restart` is high, `ras_n` and `cas_n` go high and `bus_req` and `init_done` go low.
- R2: After reset or restart, `bus_req` rises exactly PAUSE_CYC clock edges after the last edge at which `rst` or `restart` was sampled high. There is no strobe activity before that.
- R3: Initialization consists of INIT_CNT RAS-only pulses, issued under one grant, with `cas_n` high throughout. Each pulse holds `ras_n` low for RAS_W cycles. Consecutive pulses are separated by RP+RPC high cycles.
- R4: `init_done` rises, and `bus_req` falls, RP cycles after the RAS rise of the last initialization pulse. `init_done` then stays high until reset or restart.
- R5: The strobes stay high whenever `bus_req` is low. The first strobe edge comes RPC cycles after the edge at which the grant is first sampled high. `bus_req` falls RP cycles after the last RAS rise of a burst.
- R6: In a refresh cycle, `cas_n` falls CSR cycles before `ras_n` falls and rises CHR cycles after `ras_n` falls.
- R7: In a refresh cycle, `ras_n` stays low for RAS_W cycles. Consecutive refresh cycles in one burst are separated by RP+RPC cycles with RAS high.
- R8: After `init_done` rises, a refresh becomes due every REF_INT cycles. The first one is due REF_INT cycles after the rise. `bus_req` rises one cycle after a refresh becomes due while the sequencer is idle.
- R9: Up to MAX_PEND refreshes that are due but not yet granted are kept. When the grant arrives, all kept refreshes run back to back under one request. Refreshes that become due while MAX_PEND are already kept are discarded.
- R10: A restart clears the refresh backlog and drops `init_done` at the restart edge. The pause and initialization sequence then runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | One-cycle pulse that re-runs pause and initialization |
| bus_gnt | input | 1 | Bus grant from the access controller |
| bus_req | output | 1 | Bus request to the access controller |
| ras_n | output | 1 | Row strobe, active low, registered |
| cas_n | output | 1 | Column strobe, active low, registered |
| init_done | output | 1 | High once initialization has completed |

## Verification
Every output edge has a due clock edge that can be derived from the parameters. The `bus_req` rise comes PAUSE_CYC edges after reset, or one edge after a refresh becomes due. The first strobe edge comes RPC edges after the grant is sampled. Later strobe edges follow at CSR, CHR, RAS_W and RP offsets. The bench turns these offsets into absolute edge numbers and queues each expected output transition in advance. A monitor samples the outputs at each falling clock edge and compares every observed change with the head of the queue. Any change that is early, late, missing or not expected is reported as a failure.

// File: rtl/dref_pkg.sv
package dref_pkg;

  typedef enum logic [2:0] {
    S_PAUSE,
    S_IDLE,
    S_REQ,
    S_GAP,
    S_CSET,
    S_RASLO,
    S_PRE
  } seq_state_t;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dref_backlog.sv
module dref_backlog #(
  parameter int unsigned REF_INT  = 1560,
  parameter int unsigned MAX_PEND = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic take,
  output logic pend_nz
);
  localparam int unsigned RW = $clog2(REF_INT) + 1;
  localparam int unsigned PW = $clog2(MAX_PEND + 1);
  localparam logic [PW-1:0] PMAX = PW'(MAX_PEND);

  logic [RW-1:0] rcnt;
  logic [PW-1:0] pend;
  logic          due;

  assign due     = run && (rcnt == '0);
  assign pend_nz = (pend != '0);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      rcnt <= RW'(REF_INT - 1);
    end else if (rcnt == '0) begin
      rcnt <= RW'(REF_INT - 1);
    end else begin
      rcnt <= rcnt - RW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pend <= '0;
    end else if (due && !take) begin
      if (pend != PMAX) pend <= pend + PW'(1);
    end else if (take && !due) begin
      pend <= pend - PW'(1);
    end
  end

endmodule

// File: rtl/dref_seq.sv
module dref_seq
  import dref_pkg::*;
#(
  parameter int unsigned PAUSE_CYC = 20000,
  parameter int unsigned INIT_CNT  = 8,
  parameter int unsigned RAS_W     = 6,
  parameter int unsigned RP        = 4,
  parameter int unsigned RPC       = 1,
  parameter int unsigned CSR       = 1,
  parameter int unsigned CHR       = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic bus_gnt,
  input  logic pend_nz,
  output logic take,
  output logic bus_req,
  output logic ras_n,
  output logic cas_n,
  output logic init_done
);
  localparam int unsigned MAXD = max_of(max_of(max_of(PAUSE_CYC, RAS_W), max_of(RP, RPC)),
                                        max_of(CSR, CHR));
  localparam int unsigned CW = $clog2(MAXD) + 1;
  localparam int unsigned IW = $clog2(INIT_CNT + 1);

  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] hcnt;
  logic [IW-1:0] init_left;
  logic          init_mode;
  logic          more;

  assign take = (state == S_RASLO) && (cnt == '0) && !init_mode && !rst && !restart;
  assign more = init_mode ? (init_left != '0) : pend_nz;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      state     <= S_PAUSE;
      cnt       <= CW'(PAUSE_CYC - 1);
      hcnt      <= '0;
      init_left <= '0;
      init_mode <= 1'b1;
      bus_req   <= 1'b0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      init_done <= 1'b0;
    end else begin
      unique case (state)
        S_PAUSE: begin
          if (cnt == '0) begin
            state     <= S_REQ;
            bus_req   <= 1'b1;
            init_left <= IW'(INIT_CNT);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        S_IDLE: begin
          if (pend_nz) begin
            state   <= S_REQ;
            bus_req <= 1'b1;
          end
        end
        S_REQ: begin
          if (bus_gnt) begin
            state <= S_GAP;
            cnt   <= CW'(RPC - 1);
          end
        end
        S_GAP: begin
          if (cnt != '0) begin
            cnt <= cnt - CW'(1);
          end else if (init_mode) begin
            state <= S_RASLO;
            ras_n <= 1'b0;
            cnt   <= CW'(RAS_W - 1);
          end else begin
            state <= S_CSET;
            cas_n <= 1'b0;
            cnt   <= CW'(CSR - 1);
          end
        end
        S_CSET: begin
          if (cnt != '0) begin
            cnt <= cnt - CW'(1);
          end else begin
            state <= S_RASLO;
            ras_n <= 1'b0;
            cnt   <= CW'(RAS_W - 1);
            hcnt  <= CW'(CHR - 1);
          end
        end
        S_RASLO: begin
          if (!cas_n) begin
            if (hcnt == '0) cas_n <= 1'b1;
            else            hcnt  <= hcnt - CW'(1);
          end
          if (cnt != '0) begin
            cnt <= cnt - CW'(1);
          end else begin
            state <= S_PRE;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            cnt   <= CW'(RP - 1);
            if (init_mode) init_left <= init_left - IW'(1);
          end
        end
        S_PRE: begin
          if (cnt != '0) begin
            cnt <= cnt - CW'(1);
          end else if (more) begin
            state <= S_GAP;
            cnt   <= CW'(RPC - 1);
          end else begin
            state   <= S_IDLE;
            bus_req <= 1'b0;
            if (init_mode) begin
              init_mode <= 1'b0;
              init_done <= 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dref_housekeeper.sv
module dref_housekeeper #(
  parameter int unsigned PAUSE_CYC = 20000,
  parameter int unsigned INIT_CNT  = 8,
  parameter int unsigned REF_INT   = 1560,
  parameter int unsigned MAX_PEND  = 4,
  parameter int unsigned RAS_W     = 6,
  parameter int unsigned RP        = 4,
  parameter int unsigned RPC       = 1,
  parameter int unsigned CSR       = 1,
  parameter int unsigned CHR       = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic bus_gnt,
  output logic bus_req,
  output logic ras_n,
  output logic cas_n,
  output logic init_done
);
  logic pend_nz;
  logic take;

  dref_backlog #(
    .REF_INT (REF_INT),
    .MAX_PEND(MAX_PEND)
  ) u_backlog (
    .clk    (clk),
    .rst    (rst),
    .clear  (restart),
    .run    (init_done),
    .take   (take),
    .pend_nz(pend_nz)
  );

  dref_seq #(
    .PAUSE_CYC(PAUSE_CYC),
    .INIT_CNT (INIT_CNT),
    .RAS_W    (RAS_W),
    .RP       (RP),
    .RPC      (RPC),
    .CSR      (CSR),
    .CHR      (CHR)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .bus_gnt  (bus_gnt),
    .pend_nz  (pend_nz),
    .take     (take),
    .bus_req  (bus_req),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .init_done(init_done)
  );

endmodule

// File: rtl/dref_housekeeper_chk.sv
module dref_housekeeper_chk #(
  parameter int unsigned RAS_W = 6
) (
  input logic clk,
  input logic rst,
  input logic restart,
  input logic bus_req,
  input logic ras_n,
  input logic cas_n,
  input logic init_done
);
  localparam logic [15:0] RW16 = 16'(RAS_W);
  logic [15:0] lo_len;

  always_ff @(posedge clk) begin
    if (rst || ras_n) lo_len <= '0;
    else              lo_len <= lo_len + 16'd1;
  end

  // R1, R10: restart forces the idle output state
  a_r10_restart_idle: assert property (@(posedge clk) disable iff (rst)
    restart |=> (ras_n && cas_n && !bus_req && !init_done));

  // R5: no strobe activity without a bus request
  a_r5_quiet_without_req: assert property (@(posedge clk) disable iff (rst)
    !bus_req |-> (ras_n && cas_n));

  // R3: initialization pulses keep CAS high
  a_r3_init_ras_only: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && !init_done) |-> cas_n);

  // R6: refresh cycles have CAS low before RAS falls
  a_r6_cas_leads_ras: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && init_done) |-> (!cas_n && !$past(cas_n)));

  // R4: init_done only drops through restart or reset
  a_r4_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (init_done && !restart) |=> init_done);

  // R7: RAS low width
  a_r7_ras_width: assert property (@(posedge clk) disable iff (rst)
    ($rose(ras_n) && !$past(restart) && !$past(rst)) |-> (lo_len == RW16));

endmodule

bind dref_housekeeper dref_housekeeper_chk #(.RAS_W(RAS_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .restart  (restart),
  .bus_req  (bus_req),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .init_done(init_done)
);

// File: tb/dref_housekeeper_test.sv
module dref_housekeeper_test;
  localparam int PAUSE_CYC = 20;
  localparam int INIT_CNT  = 8;
  localparam int REF_INT   = 100;
  localparam int MAX_PEND  = 3;
  localparam int RAS_W     = 5;
  localparam int RP        = 4;
  localparam int RPC       = 2;
  localparam int CSR       = 2;
  localparam int CHR       = 3;

  typedef struct {
    int    id;
    logic  val;
    int    t;
    string req;
  } ev_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic restart = 1'b0;
  logic gnt_en = 1'b1;
  logic bus_gnt, bus_req, ras_n, cas_n, init_done;
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   mon_on = 1'b0;
  bit   done_flag = 1'b0;
  logic [3:0] prev;
  ev_t  exq[$];

  assign bus_gnt = bus_req & gnt_en;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dref_housekeeper #(
    .PAUSE_CYC(PAUSE_CYC), .INIT_CNT(INIT_CNT), .REF_INT(REF_INT),
    .MAX_PEND(MAX_PEND), .RAS_W(RAS_W), .RP(RP), .RPC(RPC), .CSR(CSR), .CHR(CHR)
  ) uut (
    .clk(clk), .rst(rst), .restart(restart), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .ras_n(ras_n), .cas_n(cas_n), .init_done(init_done)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic push(input int id, input logic val, input int t, input string req);
    ev_t e;
    e.id = id; e.val = val; e.t = t; e.req = req;
    exq.push_back(e);
  endtask

  // R2 R3 R4: pause, init pulses, done
  task automatic exp_init(input int t_req, output int done_t);
    int t, last;
    push(0, 1'b1, t_req, "R2");
    t = t_req + 1 + RPC;
    last = t;
    for (int i = 0; i < INIT_CNT; i++) begin
      push(1, 1'b0, t, "R3");
      push(1, 1'b1, t + RAS_W, "R3");
      last = t + RAS_W;
      t = last + RP + RPC;
    end
    done_t = last + RP;
    push(0, 1'b0, done_t, "R4");
    push(3, 1'b1, done_t, "R4");
  endtask

  // R5 R6 R7 R8: one refresh burst
  task automatic exp_ref(input int t_req, input int t_gs, input int n, input bit rise);
    int t, last;
    if (rise) push(0, 1'b1, t_req, "R8");
    t = t_gs + RPC;
    last = t;
    for (int i = 0; i < n; i++) begin
      push(2, 1'b0, t, "R6");
      push(1, 1'b0, t + CSR, "R6");
      push(2, 1'b1, t + CSR + CHR, "R6");
      push(1, 1'b1, t + CSR + RAS_W, "R7");
      last = t + CSR + RAS_W;
      t = last + RP + RPC;
    end
    push(0, 1'b0, last + RP, "R5");
  endtask

  task automatic see(input int id, input logic val);
    ev_t e;
    checks++;
    if (exq.size() == 0) begin
      fails++;
      $display("FAIL R5 unexpected change sig=%0d actual=%b@%0d expected=none", id, val, cyc);
      return;
    end
    e = exq.pop_front();
    if (e.id != id || e.val !== val || e.t != cyc) begin
      fails++;
      $display("FAIL %s actual sig=%0d val=%b t=%0d expected sig=%0d val=%b t=%0d",
               e.req, id, val, cyc, e.id, e.val, e.t);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (bus_req   !== prev[0]) see(0, bus_req);
      if (ras_n     !== prev[1]) see(1, ras_n);
      if (cas_n     !== prev[2]) see(2, cas_n);
      if (init_done !== prev[3]) see(3, init_done);
      prev = {init_done, cas_n, ras_n, bus_req};
    end
  end

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    int t0, d1, g, x, d2;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", ras_n, 1'b1, "ras_n in reset");
    check("R1", cas_n, 1'b1, "cas_n in reset");
    check("R1", bus_req, 1'b0, "bus_req in reset");
    check("R1", init_done, 1'b0, "init_done in reset");
    t0 = cyc;
    exp_init(t0 + PAUSE_CYC, d1);
    exp_ref(d1 + REF_INT + 1, d1 + REF_INT + 2, 1, 1'b1);
    exp_ref(d1 + 2*REF_INT + 1, d1 + 2*REF_INT + 2, 1, 1'b1);
    // R9: grant withheld while ticks 3..6 accumulate, saturating at MAX_PEND
    g = d1 + 620;
    push(0, 1'b1, d1 + 3*REF_INT + 1, "R8");
    exp_ref(0, g + 1, MAX_PEND, 1'b0);
    exp_ref(d1 + 7*REF_INT + 1, d1 + 7*REF_INT + 2, 1, 1'b1);
    // R10: restart from idle
    x = d1 + 761;
    push(3, 1'b0, x, "R10");
    exp_init(x + PAUSE_CYC, d2);
    exp_ref(d2 + REF_INT + 1, d2 + REF_INT + 2, 1, 1'b1);
    prev = {init_done, cas_n, ras_n, bus_req};
    mon_on = 1'b1;
    rst = 1'b0;
    wait_cyc(d1 + 250);
    gnt_en = 1'b0;
    wait_cyc(g);
    gnt_en = 1'b1;
    wait_cyc(x - 1);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    wait_cyc(d2 + REF_INT + 40);
    // R9 R8: every expected transition has occurred
    checks++;
    if (exq.size() != 0) begin
      fails++;
      $display("FAIL R9 pending events actual=%0d expected=0", exq.size());
    end
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    finish_run();
  end

endmodule